// File: doc/BRIEF.md
# Dual-Rail Handshaked Register Stage

This block is a clock-sampled model of one register stage in a self-timed, delay-insensitive pipeline. The stage carries a bus of `WIDTH` bits, and each bit travels as a pair of rails. In one pair, the true rail high means logic 1 and the false rail high means logic 0. When both rails are low the bit carries no value, which is the spacer. When both rails are high the code is illegal. A valid word, where every bit holds a value, must always be followed by a full spacer before the next valid word can pass.

Each rail of the stage is held by a hysteresis cell. A cell sets only when its rail is high and the following stage asks for data. It clears only when the whole input is spacer and the following stage asks for a spacer. Completion detection over the held outputs produces the stage's own request signal for the preceding stage. The capture and release conditions are gated at word level, so the held word moves between all-spacer and all-valid as one unit. A sticky flag records any illegal pair seen on the inputs or the outputs.

Top module: `ncl_dr_reg_stage`

## Requirements
- R1: While reset is low at a clock edge, all output rails go to 0 (spacer), `ack_out` goes to 1 (request for data) and `err_flag` goes to 0.
- R2: Input bit i carries 1 when `in_t[i]`=1 and `in_f[i]`=0, and carries 0 when `in_t[i]`=0 and `in_f[i]`=1. Suppose the outputs are all spacer, `ack_in`=1 and every input pair holds a value. Then on the next edge the outputs copy the input rails exactly.
- R3: While the outputs are all spacer, an input word in which any pair is still spacer is not captured, and the outputs stay all 0.
- R4: Held outputs return to all spacer on the next edge only when every input pair is spacer (00) and `ack_in`=0. If any input pair still holds a value, the held word stays unchanged.
- R5: When `ack_in`=0, a valid input word is not captured into spacer outputs. When `ack_in`=1, held outputs do not return to spacer.
- R6: `ack_out` becomes 0 on the edge after the outputs are all valid, and becomes 1 on the edge after the outputs are all spacer. Otherwise it holds.
- R7: An input pair of 11 sets `err_flag` on the next edge, and that word is never captured.
- R8: Once set, `err_flag` stays 1 until reset.
- R9: No output pair is ever 11.
- R10: Words pass in order and with their values intact under any timing of the handshake on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_t | input | WIDTH | True rails of the incoming bus |
| in_f | input | WIDTH | False rails of the incoming bus |
| ack_in | input | 1 | Request from the following stage: 1 asks for data, 0 asks for spacer |
| out_t | output | WIDTH | True rails of the held bus |
| out_f | output | WIDTH | False rails of the held bus |
| ack_out | output | 1 | Request to the preceding stage: 1 asks for data, 0 asks for spacer |
| err_flag | output | 1 | Sticky flag for an illegal 11 pair |

## Verification
The hardest case to reach is a held word facing a partly changed input. This means a spacer that has reached only some pairs while the following stage already asks for spacer, or a complete valid word arriving while the following stage still asks for spacer. A normal handshake never lets such an input stay in place for a whole cycle. For every one of the 16 four-bit words, the bench therefore drives the two rail buses and `ack_in` directly. It holds each half-finished wavefront for a cycle before finishing it, and after that it runs a stream with random delays on both handshake sides and checks the order of the words.

// File: rtl/ncl_dr_pkg.sv
// Package: shared handshake encoding and per-pair classification helpers
// for the dual-rail register stage. Assumes rail pair order {true,false}.
package ncl_dr_pkg;

    // Handshake level seen on ack lines.
    typedef enum logic {
        REQ_NULL = 1'b0,
        REQ_DATA = 1'b1
    } hs_req_e;

    // Pair holds exactly one asserted rail (a value).
    function automatic logic pair_valid(input logic rt, input logic rf);
        return rt ^ rf;
    endfunction

    // Pair holds the spacer code.
    function automatic logic pair_spacer(input logic rt, input logic rf);
        return ~(rt | rf);
    endfunction

    // Pair holds the illegal code.
    function automatic logic pair_clash(input logic rt, input logic rf);
        return rt & rf;
    endfunction

endpackage

// File: rtl/ncl_dr_comp_det.sv
// Completion detector: classifies a dual-rail bus as fully valid, fully
// spacer, and flags any illegal pair. Purely combinational.
// Assumes WIDTH >= 1.
module ncl_dr_comp_det
    import ncl_dr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic             all_valid,
    output logic             all_spacer,
    output logic             any_clash
);

    logic [WIDTH-1:0] bit_valid;
    logic [WIDTH-1:0] bit_spacer;
    logic [WIDTH-1:0] bit_clash;

    // Per-pair classification.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        assign bit_valid[i]  = pair_valid(rail_t[i], rail_f[i]);
        assign bit_spacer[i] = pair_spacer(rail_t[i], rail_f[i]);
        assign bit_clash[i]  = pair_clash(rail_t[i], rail_f[i]);
    end

    // Reduce the per-pair results into word-level completion.
    always_comb begin
        all_valid  = &bit_valid;
        all_spacer = &bit_spacer;
        any_clash  = |bit_clash;
    end

endmodule

// File: rtl/ncl_dr_hyst_cell.sv
// Hysteresis cell for one rail: sets on set_en, clears on clr_en,
// otherwise holds. Assumes set_en and clr_en are never high together.
// Reset value is 0 (spacer).
module ncl_dr_hyst_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    output logic rail_q
);

    // Hold state, moving only on a full set or full clear condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rail_q <= 1'b0;
        end else if (set_en) begin
            rail_q <= 1'b1;
        end else if (clr_en) begin
            rail_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ncl_dr_ack_gen.sv
// Request generator: turns output completion into the request sent to the
// preceding stage. Requests spacer once outputs are all valid and data
// once outputs are all spacer; holds in between. Resets to request-data.
module ncl_dr_ack_gen
    import ncl_dr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic out_all_valid,
    input  logic out_all_spacer,
    output logic ack_q
);

    hs_req_e req_q;

    // Track completion of the held word with hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= REQ_DATA;
        end else if (out_all_valid) begin
            req_q <= REQ_NULL;
        end else if (out_all_spacer) begin
            req_q <= REQ_DATA;
        end
    end

    assign ack_q = req_q;

endmodule

// File: rtl/ncl_dr_err_sticky.sv
// Sticky error latch: raised by any illegal pair on either side of the
// stage, cleared only by reset.
module ncl_dr_err_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic in_clash,
    input  logic out_clash,
    output logic err_q
);

    // Accumulate illegal-code events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (in_clash || out_clash) begin
            err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ncl_dr_reg_stage.sv
// Dual-rail register stage. Each rail is held by a hysteresis cell that
// captures a complete valid word when the next stage asks for data and the
// stage is empty, and releases to spacer only when the whole input is spacer
// and the next stage asks for spacer. Assumes the producer honours ack_out.
module ncl_dr_reg_stage
    import ncl_dr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_t,
    input  logic [WIDTH-1:0] in_f,
    input  logic             ack_in,
    output logic [WIDTH-1:0] out_t,
    output logic [WIDTH-1:0] out_f,
    output logic             ack_out,
    output logic             err_flag
);

    localparam int NRAIL = 2 * WIDTH;

    logic             in_all_valid, in_all_spacer, in_any_clash;
    logic             out_all_valid, out_all_spacer, out_any_clash;
    logic             capture_go, release_go;
    logic [NRAIL-1:0] rail_in;
    logic [NRAIL-1:0] rail_q;

    // Completion over the incoming wavefront.
    ncl_dr_comp_det #(.WIDTH(WIDTH)) in_det_i (
        .rail_t    (in_t),
        .rail_f    (in_f),
        .all_valid (in_all_valid),
        .all_spacer(in_all_spacer),
        .any_clash (in_any_clash)
    );

    // Completion over the held wavefront.
    ncl_dr_comp_det #(.WIDTH(WIDTH)) out_det_i (
        .rail_t    (out_t),
        .rail_f    (out_f),
        .all_valid (out_all_valid),
        .all_spacer(out_all_spacer),
        .any_clash (out_any_clash)
    );

    // Word-level gating of set and clear for the rail cells.
    always_comb begin
        capture_go = (ack_in == REQ_DATA) && in_all_valid && out_all_spacer;
        release_go = (ack_in == REQ_NULL) && in_all_spacer;
    end

    assign rail_in = {in_f, in_t};

    // One hysteresis cell per rail.
    for (genvar r = 0; r < NRAIL; r++) begin : g_rail
        ncl_dr_hyst_cell cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set_en(capture_go && rail_in[r]),
            .clr_en(release_go),
            .rail_q(rail_q[r])
        );
    end

    assign out_t = rail_q[WIDTH-1:0];
    assign out_f = rail_q[NRAIL-1:WIDTH];

    // Request back to the preceding stage.
    ncl_dr_ack_gen ack_gen_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .out_all_valid (out_all_valid),
        .out_all_spacer(out_all_spacer),
        .ack_q         (ack_out)
    );

    // Illegal-code monitor.
    ncl_dr_err_sticky err_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_clash (in_any_clash),
        .out_clash(out_any_clash),
        .err_q    (err_flag)
    );

endmodule

// File: rtl/ncl_dr_reg_stage_chk.sv
// Checker for the dual-rail register stage, bound to every instance.
// Derives completion of input and output from the ports only.
module ncl_dr_reg_stage_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] in_t,
    input logic [WIDTH-1:0] in_f,
    input logic             ack_in,
    input logic [WIDTH-1:0] out_t,
    input logic [WIDTH-1:0] out_f,
    input logic             ack_out,
    input logic             err_flag
);

    logic i_full, i_empty, i_bad, o_full, o_empty;
    assign i_full  = ((in_t ^ in_f) == '1);
    assign i_empty = ((in_t | in_f) == '0);
    assign i_bad   = ((in_t & in_f) != '0);
    assign o_full  = ((out_t ^ out_f) == '1);
    assign o_empty = ((out_t | out_f) == '0);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (o_empty && ack_out && !err_flag));

    // R2
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_empty && ack_in && i_full) |=>
        (out_t == $past(in_t) && out_f == $past(in_f)));

    // R3
    no_partial_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_empty && !i_full) |=> o_empty);

    // R4
    hold_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_full && !(!ack_in && i_empty)) |=> ($stable(out_t) && $stable(out_f)));

    // R5
    no_capture_on_rfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_empty && !ack_in) |=> o_empty);

    // R6
    ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_full |=> !ack_out);

    // R6
    ack_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_empty |=> ack_out);

    // R7
    clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i_bad |=> err_flag);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R9
    no_out_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_t & out_f) == '0));

endmodule

bind ncl_dr_reg_stage ncl_dr_reg_stage_chk #(.WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_t    (in_t),
    .in_f    (in_f),
    .ack_in  (ack_in),
    .out_t   (out_t),
    .out_f   (out_f),
    .ack_out (ack_out),
    .err_flag(err_flag)
);

// File: tb/ncl_dr_reg_stage_tb.sv
// Bench: exhaustive sweep of every 4-bit word through the half-finished
// wavefront cases, then a randomly timed stream, then illegal codes.
module ncl_dr_reg_stage_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_t = '0;
    logic [W-1:0] in_f = '0;
    logic         ack_in = 1'b1;
    logic [W-1:0] out_t, out_f;
    logic         ack_out, err_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ncl_dr_reg_stage #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .ack_in(ack_in),
        .out_t(out_t), .out_f(out_f), .ack_out(ack_out), .err_flag(err_flag)
    );

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // Drive a full value word: true rail = bit, false rail = inverted bit.
    task automatic drive_word(input logic [W-1:0] w);
        in_t = w;
        in_f = ~w;
    endtask

    function automatic int pack_out();
        return {out_f, out_t};
    endfunction

    function automatic int word_rails(input logic [W-1:0] w);
        return {~w, w};
    endfunction

    logic [W-1:0] exp_q[$];

    initial begin
        @(negedge clk);
        step();
        step();
        // R1 reset state
        chk(pack_out() == 0, "R1 out", pack_out(), 0);
        chk(ack_out == 1'b1, "R1 ack", ack_out, 1);
        chk(err_flag == 1'b0, "R1 err", err_flag, 0);
        rst_n = 1'b1;
        step();

        // Exhaustive sweep of every word value.
        for (int w = 0; w < (1 << W); w++) begin
            ack_in = 1'b1;
            drive_word(w[W-1:0]);
            in_t[w % W] = 1'b0;
            in_f[w % W] = 1'b0;
            step();
            chk(pack_out() == 0, "R3 partial", pack_out(), 0);
            drive_word(w[W-1:0]);
            step();
            chk(pack_out() == word_rails(w[W-1:0]), "R2 capture", pack_out(), word_rails(w[W-1:0]));
            step();
            chk(ack_out == 1'b0, "R6 ack low", ack_out, 0);
            in_t = '0; in_f = '0;
            step();
            chk(pack_out() == word_rails(w[W-1:0]), "R5 hold on rfd", pack_out(), word_rails(w[W-1:0]));
            ack_in = 1'b0;
            drive_word(w[W-1:0]);
            in_t[(w + 1) % W] = 1'b0;
            in_f[(w + 1) % W] = 1'b0;
            step();
            chk(pack_out() == word_rails(w[W-1:0]), "R4 partial spacer", pack_out(), word_rails(w[W-1:0]));
            in_t = '0; in_f = '0;
            step();
            chk(pack_out() == 0, "R4 release", pack_out(), 0);
            step();
            chk(ack_out == 1'b1, "R6 ack high", ack_out, 1);
            drive_word(w[W-1:0]);
            step();
            chk(pack_out() == 0, "R5 no capture on rfn", pack_out(), 0);
            in_t = '0; in_f = '0;
            ack_in = 1'b1;
            step();
        end

        // R10: randomly timed stream, order and value preserved.
        void'($urandom(7));
        for (int k = 0; k < 60; k++) begin
            logic [W-1:0] wv;
            wv = W'($urandom);
            exp_q.push_back(wv);
            ack_in = 1'b0;
            for (int g = 0; g < 50 && ack_out != 1'b1; g++) step();
            repeat ($urandom % 4) step();
            drive_word(wv);
            repeat ($urandom % 4) step();
            ack_in = 1'b1;
            for (int g = 0; g < 50 && ((out_t ^ out_f) != '1); g++) step();
            begin
                logic [W-1:0] ev;
                ev = exp_q.pop_front();
                chk(out_t == ev && out_f == ~ev, "R10 order", pack_out(), word_rails(ev));
            end
            for (int g = 0; g < 50 && ack_out != 1'b0; g++) step();
            repeat ($urandom % 4) step();
            in_t = '0; in_f = '0;
            repeat ($urandom % 4) step();
            ack_in = 1'b0;
            for (int g = 0; g < 50 && ((out_t | out_f) != '0); g++) step();
            chk(pack_out() == 0, "R10 spacer", pack_out(), 0);
        end

        // R7: illegal pair flagged, not captured.
        ack_in = 1'b1;
        step();
        chk(err_flag == 1'b0, "R8 clean before", err_flag, 0);
        in_t = 4'b0101;
        in_f = 4'b1011;
        step();
        chk(err_flag == 1'b1, "R7 flag", err_flag, 1);
        chk(pack_out() == 0, "R7 no capture", pack_out(), 0);
        chk((out_t & out_f) == '0, "R9 no out clash", pack_out(), 0);
        in_t = '0; in_f = '0;
        drive_word(4'h9);
        step();
        step();
        chk(err_flag == 1'b1, "R8 sticky", err_flag, 1);
        chk(pack_out() == word_rails(4'h9), "R2 after error", pack_out(), word_rails(4'h9));
        rst_n = 1'b0;
        step();
        chk(err_flag == 1'b0, "R1 err cleared", err_flag, 0);
        chk(pack_out() == 0, "R1 out cleared", pack_out(), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule